// File: doc/BRIEF.md
# Column Readout Sequencer

This block produces the timing for reading out one column of front-end analog multiplexer chips and their digitizing, zero-suppressing companion chips. It runs from the master clock and builds a slower readout period by dividing that clock by 4, 5, 8 or 32. A start strobe launches a readout. The block then releases the track-and-hold control and waits one idle readout period. After that it issues a programmed number of clock pulses to the first chip type. A copy of each pulse, delayed by half a period, goes to the second chip type. The block re-arms track-and-hold after the last period and flags completion.

Each pulse belongs to one channel. In read mode the word on the chip data input is pushed into an upstream FIFO at the end of the pulse's period. In write mode a word is popped from a show-ahead downstream FIFO at the start of the period and driven to the chips. In bypass mode only the clocks run. A per-channel mask suppresses the data transfer for the channels it selects, but their pulses are still issued. Mode, pulse count, divider and mask are captured when a readout starts.

Top module: `col_rdo_seq`

## Requirements
- R1: `cfg_cnt_sel` selects the number of pulses per readout: 00 gives 16, 01 gives 32, 10 gives 48 and 11 gives 64.
- R2: `cfg_div_sel` selects the readout period N in master cycles: 00 gives 4, 01 gives 5, 10 gives 8 and 11 gives 32. Each `clk_a` pulse stays high for floor(N/2) master cycles.
- R3: `clk_b` has the same pulses as `clk_a`, each rising floor(N/2) master cycles after the matching `clk_a` rise. The two clocks are never high together.
- R4: `th_arm` (1 = armed) goes low in the cycle after a start is accepted. The first `clk_a` rise comes exactly N cycles later. `th_arm` returns high after (pulses+1)·N cycles, once the last period has ended.
- R5: `done` is high for exactly one cycle, in the same cycle that `busy` falls and `th_arm` returns high, (pulses+1)·N cycles after the start is accepted.
- R6: Read mode (`cfg_mode` 00) makes one `rd_push` for each unmasked channel, in increasing channel order. `rd_chan` carries the channel number (pulse k is channel k−1). `rd_data` carries `chip_din` as sampled in the last master cycle of that pulse's period.
- R7: Write mode (`cfg_mode` 01) makes one `wr_pop` for each unmasked channel, in the first master cycle of its period. `chip_dout` takes `wr_data` from the pop cycle on the following cycle.
- R8: Bypass modes (`cfg_mode` 10 and 11) issue all pulses but assert neither `rd_push` nor `wr_pop`.
- R9: Mask bit i = 1 removes the data transfer of channel i, while its clock pulse is still issued.
- R10: While `rd_full` is high no push is made, and the word for that channel is dropped. While `wr_empty` is high no pop is made.
- R11: A start strobe while `busy` is high is ignored. A configuration change during a readout does not affect that readout.
- R12: After reset `busy`, `done`, `clk_a`, `clk_b`, `rd_push` and `wr_pop` are low and `th_arm` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Readout start strobe |
| cfg_mode | input | 2 | 00 read, 01 write, 10/11 bypass |
| cfg_cnt_sel | input | 2 | Pulse count select |
| cfg_div_sel | input | 2 | Readout period select |
| cfg_chan_mask | input | NCH | Per-channel transfer mask, 1 = bypassed |
| chip_din | input | DW | Data from the digitizing chips |
| rd_full | input | 1 | Upstream FIFO full |
| wr_empty | input | 1 | Downstream FIFO empty |
| wr_data | input | DW | Downstream FIFO head word (show-ahead) |
| busy | output | 1 | Readout in progress |
| done | output | 1 | One-cycle end-of-readout flag |
| th_arm | output | 1 | Track-and-hold control, 1 = armed |
| clk_a | output | 1 | Readout clock for the first chip type |
| clk_b | output | 1 | Half-period delayed clock for the second chip type |
| rd_push | output | 1 | Push strobe to upstream FIFO |
| rd_data | output | DW | Word pushed |
| rd_chan | output | log2(NCH) | Channel of the pushed word |
| wr_pop | output | 1 | Pop strobe to downstream FIFO |
| chip_dout | output | DW | Word driven to the chips |

## Verification
A table of readouts covers every pulse-count code and every divider code. It includes both an odd ratio and the widest ratio, so a wrong period or a wrong half-period position shows up as wrong rise times, high counts and clock lag. The mask patterns are empty, sparse, all-but-one and top-channel-only. Run in both read and write mode, they tell a skipped pulse apart from a skipped transfer and show whether channel order and data capture timing are right. The table also has rows with the FIFO full or empty and rows in both bypass codes, to separate the mode decode from the flow-control gating. Directed runs fire a second start and change the pulse count in mid-readout, and they check the reset state.

// File: rtl/col_rdo_pkg.sv
package col_rdo_pkg;

  typedef enum logic [1:0] {
    MODE_READ  = 2'b00,
    MODE_WRITE = 2'b01,
    MODE_BYP   = 2'b10,
    MODE_BYP2  = 2'b11
  } rdo_mode_e;

  // Master-clock cycles per readout period
  function automatic int unsigned div_ratio(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4;
      2'b01:   return 5;
      2'b10:   return 8;
      default: return 32;
    endcase
  endfunction

  // Pulses per readout: 16 * (sel + 1)
  function automatic int unsigned pulse_total(input logic [1:0] sel);
    return 16 * (int'(sel) + 1);
  endfunction

endpackage

// File: rtl/col_rdo_timer.sv
module col_rdo_timer
  import col_rdo_pkg::*;
#(
  parameter int unsigned CW = 7,
  parameter int unsigned PW = 6
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          start,
  input  logic [1:0]    cnt_sel,
  input  logic [1:0]    div_sel,
  output logic          ld,
  output logic          busy_q,
  output logic          busy_nx,
  output logic          done_q,
  output logic          ph_last,
  output logic [PW-1:0] ph_q,
  output logic [PW-1:0] ph_nx,
  output logic [PW-1:0] half,
  output logic [CW-1:0] per_q,
  output logic [CW-1:0] per_nx
);

  logic [PW-1:0] ratio_q;
  logic [CW-1:0] np_q;
  logic          done_nx;

  assign ld      = start & ~busy_q;
  assign half    = ratio_q >> 1;
  assign ph_last = busy_q && (ph_q == ratio_q - PW'(1));

  // Period 0 is the idle period after track-and-hold release,
  // periods 1..np_q each carry one pulse.
  always_comb begin
    ph_nx   = ph_q;
    per_nx  = per_q;
    busy_nx = busy_q;
    done_nx = 1'b0;
    if (ld) begin
      busy_nx = 1'b1;
      ph_nx   = '0;
      per_nx  = '0;
    end else if (busy_q) begin
      if (ph_last) begin
        ph_nx = '0;
        if (per_q == np_q) begin
          busy_nx = 1'b0;
          done_nx = 1'b1;
          per_nx  = '0;
        end else begin
          per_nx = per_q + CW'(1);
        end
      end else begin
        ph_nx = ph_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      ph_q    <= '0;
      per_q   <= '0;
      ratio_q <= PW'(4);
      np_q    <= CW'(16);
    end else begin
      busy_q <= busy_nx;
      done_q <= done_nx;
      ph_q   <= ph_nx;
      per_q  <= per_nx;
      if (ld) begin
        ratio_q <= PW'(div_ratio(div_sel));
        np_q    <= CW'(pulse_total(cnt_sel));
      end
    end
  end

  // R1: the period index never runs past the latched pulse count
  p_per_bound_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_q |-> (per_q <= np_q));

  // R5: completion flag lasts one cycle and coincides with idle
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    done_q |-> !busy_q);

  // R11: a strobe during a readout does not restart the period counter
  p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && start && !ph_last) |=> (ph_q == $past(ph_q) + PW'(1)));

endmodule

// File: rtl/col_rdo_clkgen.sv
module col_rdo_clkgen #(
  parameter int unsigned CW     = 7,
  parameter int unsigned PW     = 6,
  parameter int unsigned NPHASE = 2
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              busy_nx,
  input  logic [PW-1:0]     ph_nx,
  input  logic [CW-1:0]     per_nx,
  input  logic [PW-1:0]     half,
  output logic [NPHASE-1:0] ck_q,
  output logic              th_arm_q
);

  logic in_pulse_nx;
  assign in_pulse_nx = busy_nx && (per_nx != '0);

  // Each phase i is a half-period window delayed by i half periods,
  // decoded from next state so outputs line up with the counters.
  for (genvar i = 0; i < NPHASE; i++) begin : g_phase
    logic [PW-1:0] off;
    logic          hi_nx;
    assign off   = (i == 0) ? '0 : PW'(i) * half;
    assign hi_nx = in_pulse_nx && (ph_nx >= off) && (ph_nx < off + half);

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) ck_q[i] <= 1'b0;
      else         ck_q[i] <= hi_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) th_arm_q <= 1'b1;
    else         th_arm_q <= ~busy_nx;
  end

  // R3: the two chip clocks never overlap
  p_phase_excl_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    !(ck_q[0] && ck_q[1]));

  // R4: clocks only run while track-and-hold is released
  p_clk_in_window_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (ck_q[0] || ck_q[1]) |-> !th_arm_q);

endmodule

// File: rtl/col_rdo_xfer.sv
module col_rdo_xfer
  import col_rdo_pkg::*;
#(
  parameter int unsigned NCH = 64,
  parameter int unsigned DW  = 10,
  parameter int unsigned CW  = 7,
  parameter int unsigned PW  = 6,
  localparam int unsigned CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           ld,
  input  logic [1:0]     cfg_mode,
  input  logic [NCH-1:0] cfg_mask,
  input  logic           busy_q,
  input  logic           ph_last,
  input  logic [CW-1:0]  per_q,
  input  logic           busy_nx,
  input  logic [PW-1:0]  ph_nx,
  input  logic [CW-1:0]  per_nx,
  input  logic [DW-1:0]  chip_din,
  input  logic           rd_full,
  input  logic           wr_empty,
  input  logic [DW-1:0]  wr_data,
  output logic           rd_push,
  output logic [DW-1:0]  rd_data,
  output logic [CHW-1:0] rd_chan,
  output logic           wr_pop,
  output logic [DW-1:0]  chip_dout
);

  rdo_mode_e      mode_q;
  logic [NCH-1:0] mask_q;
  logic [CHW-1:0] ch_cur, ch_nx;
  logic           push_nx, pop_nx;

  assign ch_cur = CHW'(per_q - CW'(1));
  assign ch_nx  = CHW'(per_nx - CW'(1));

  // Read: capture at the last master cycle of the pulse period
  assign push_nx = busy_q && (per_q != '0) && ph_last &&
                   (mode_q == MODE_READ) && !mask_q[ch_cur] && !rd_full;

  // Write: pop in the first master cycle of the pulse period
  assign pop_nx  = busy_nx && (per_nx != '0) && (ph_nx == '0) &&
                   (mode_q == MODE_WRITE) && !mask_q[ch_nx] && !wr_empty;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_BYP;
      mask_q    <= '0;
      rd_push   <= 1'b0;
      rd_data   <= '0;
      rd_chan   <= '0;
      wr_pop    <= 1'b0;
      chip_dout <= '0;
    end else begin
      if (ld) begin
        mode_q <= rdo_mode_e'(cfg_mode);
        mask_q <= cfg_mask;
      end
      rd_push <= push_nx;
      if (push_nx) begin
        rd_data <= chip_din;
        rd_chan <= ch_cur;
      end
      wr_pop <= pop_nx;
      if (wr_pop) chip_dout <= wr_data;
    end
  end

  // R8: data never moves both ways at once
  p_one_dir_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    !(rd_push && wr_pop));

  // R10: a push only follows a cycle where the FIFO had room
  p_push_room_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_push |-> $past(!rd_full));

  // R10: a pop only follows a cycle where the FIFO held data
  p_pop_avail_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_pop |-> $past(!wr_empty));

endmodule

// File: rtl/col_rdo_seq.sv
module col_rdo_seq
  import col_rdo_pkg::*;
#(
  parameter int unsigned NCH = 64,  // must cover the largest pulse count (64)
  parameter int unsigned DW  = 10,
  localparam int unsigned CHW = $clog2(NCH),
  localparam int unsigned CW  = $clog2(NCH + 1),
  localparam int unsigned PW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     cfg_mode,
  input  logic [1:0]     cfg_cnt_sel,
  input  logic [1:0]     cfg_div_sel,
  input  logic [NCH-1:0] cfg_chan_mask,
  input  logic [DW-1:0]  chip_din,
  input  logic           rd_full,
  input  logic           wr_empty,
  input  logic [DW-1:0]  wr_data,
  output logic           busy,
  output logic           done,
  output logic           th_arm,
  output logic           clk_a,
  output logic           clk_b,
  output logic           rd_push,
  output logic [DW-1:0]  rd_data,
  output logic [CHW-1:0] rd_chan,
  output logic           wr_pop,
  output logic [DW-1:0]  chip_dout
);

  // Asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic          ld, busy_q, busy_nx, done_q, ph_last;
  logic [PW-1:0] ph_q, ph_nx, half;
  logic [CW-1:0] per_q, per_nx;
  logic [1:0]    ck_q;
  logic          th_arm_q;

  col_rdo_timer #(.CW(CW), .PW(PW)) u_timer (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .start   (start),
    .cnt_sel (cfg_cnt_sel),
    .div_sel (cfg_div_sel),
    .ld      (ld),
    .busy_q  (busy_q),
    .busy_nx (busy_nx),
    .done_q  (done_q),
    .ph_last (ph_last),
    .ph_q    (ph_q),
    .ph_nx   (ph_nx),
    .half    (half),
    .per_q   (per_q),
    .per_nx  (per_nx)
  );

  col_rdo_clkgen #(.CW(CW), .PW(PW), .NPHASE(2)) u_clkgen (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .busy_nx  (busy_nx),
    .ph_nx    (ph_nx),
    .per_nx   (per_nx),
    .half     (half),
    .ck_q     (ck_q),
    .th_arm_q (th_arm_q)
  );

  col_rdo_xfer #(.NCH(NCH), .DW(DW), .CW(CW), .PW(PW)) u_xfer (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .ld        (ld),
    .cfg_mode  (cfg_mode),
    .cfg_mask  (cfg_chan_mask),
    .busy_q    (busy_q),
    .ph_last   (ph_last),
    .per_q     (per_q),
    .busy_nx   (busy_nx),
    .ph_nx     (ph_nx),
    .per_nx    (per_nx),
    .chip_din  (chip_din),
    .rd_full   (rd_full),
    .wr_empty  (wr_empty),
    .wr_data   (wr_data),
    .rd_push   (rd_push),
    .rd_data   (rd_data),
    .rd_chan   (rd_chan),
    .wr_pop    (wr_pop),
    .chip_dout (chip_dout)
  );

  assign busy   = busy_q;
  assign done   = done_q;
  assign th_arm = th_arm_q;
  assign clk_a  = ck_q[0];
  assign clk_b  = ck_q[1];

  // R5: completion re-arms track-and-hold
  p_done_rearm_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> th_arm);

  // R6: pushes happen only inside a released window or as it closes
  p_push_window_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_push |-> (!th_arm || done));

endmodule

// File: tb/test_col_rdo_seq.sv
module test_col_rdo_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 64;
  localparam int DW  = 10;

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  cnt;
    logic [1:0]  div;
    logic [63:0] mask;
    logic        full;
    logic        empty;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 2'd0, 2'd0, 64'h0,                  1'b0, 1'b0},
    '{2'b00, 2'd1, 2'd1, 64'h0000_0000_8000_0005, 1'b0, 1'b0},
    '{2'b01, 2'd2, 2'd2, 64'h0000_F000_0000_0001, 1'b0, 1'b0},
    '{2'b10, 2'd3, 2'd3, 64'h0,                  1'b0, 1'b0},
    '{2'b00, 2'd3, 2'd0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b0},
    '{2'b00, 2'd0, 2'd2, 64'h0,                  1'b1, 1'b0},
    '{2'b01, 2'd0, 2'd1, 64'h0,                  1'b0, 1'b1},
    '{2'b11, 2'd1, 2'd0, 64'h0,                  1'b0, 1'b0},
    '{2'b01, 2'd3, 2'd0, 64'h8000_0000_0000_0000, 1'b0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [1:0]    cfg_mode, cfg_cnt_sel, cfg_div_sel;
  logic [NCH-1:0] cfg_chan_mask;
  logic [DW-1:0] chip_din;
  logic          rd_full, wr_empty;
  logic [DW-1:0] wr_data;
  logic          busy, done, th_arm, clk_a, clk_b, rd_push, wr_pop;
  logic [DW-1:0] rd_data, chip_dout;
  logic [5:0]    rd_chan;
  logic [DW-1:0] wr_cnt;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  col_rdo_seq #(.NCH(NCH), .DW(DW)) i_col_rdo_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_mode(cfg_mode), .cfg_cnt_sel(cfg_cnt_sel), .cfg_div_sel(cfg_div_sel),
    .cfg_chan_mask(cfg_chan_mask), .chip_din(chip_din),
    .rd_full(rd_full), .wr_empty(wr_empty), .wr_data(wr_data),
    .busy(busy), .done(done), .th_arm(th_arm), .clk_a(clk_a), .clk_b(clk_b),
    .rd_push(rd_push), .rd_data(rd_data), .rd_chan(rd_chan),
    .wr_pop(wr_pop), .chip_dout(chip_dout)
  );

  // Show-ahead downstream FIFO model: head word is a running count
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wr_cnt <= '0;
    else if (wr_pop) wr_cnt <= wr_cnt + 1'b1;
  end
  assign wr_data = wr_cnt;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ratio_of(input logic [1:0] s);
    case (s)
      2'd0: return 4;
      2'd1: return 5;
      2'd2: return 8;
      default: return 32;
    endcase
  endfunction

  task automatic run_seq(input vec_t v, input bit disturb);
    int n, h, np, unmasked, exp_xfer, exp_ch;
    int rises_a, rises_b, high_a, lag_err, th_low, pushes, pops;
    int chan_err, data_err, first_rise, last_rise, done_t, dones;
    bit prev_a, prev_b;
    logic [DW-1:0] wr_base;
    n  = ratio_of(v.div);
    h  = n / 2;
    np = 16 * (int'(v.cnt) + 1);
    unmasked = 0;
    for (int i = 0; i < np; i++) if (!v.mask[i]) unmasked++;
    exp_xfer = 0;
    rises_a = 0; rises_b = 0; high_a = 0; lag_err = 0; th_low = 0;
    pushes = 0; pops = 0; chan_err = 0; data_err = 0;
    first_rise = -1; last_rise = -100; done_t = -1; dones = 0;
    prev_a = 0; prev_b = 0; exp_ch = 0;

    @(negedge clk);
    cfg_mode = v.mode; cfg_cnt_sel = v.cnt; cfg_div_sel = v.div;
    cfg_chan_mask = v.mask; rd_full = v.full; wr_empty = v.empty;
    chip_din = '0; start = 1'b1;
    wr_base = wr_cnt;
    for (int t = 0; t < 4000; t++) begin
      @(negedge clk);
      if (t == 0) start = 1'b0;
      if (disturb && t == 10) begin start = 1'b1; cfg_cnt_sel = 2'd3; cfg_div_sel = 2'd3; end
      if (disturb && t == 11) start = 1'b0;
      if (clk_a && !prev_a) begin
        rises_a++; last_rise = t;
        if (first_rise < 0) first_rise = t;
      end
      if (clk_b && !prev_b) begin
        rises_b++;
        if (t - last_rise != h) lag_err++;
      end
      if (clk_a) high_a++;
      if (!th_arm) th_low++;
      if (rd_push) begin
        pushes++;
        while (exp_ch < np && v.mask[exp_ch]) exp_ch++;
        if (int'(rd_chan) != exp_ch) chan_err++;
        if (int'(rd_data) != int'(rd_chan) + 1) data_err++;
        exp_ch++;
      end
      if (wr_pop) pops++;
      prev_a = clk_a; prev_b = clk_b;
      chip_din = DW'(rises_a);
      if (done) begin
        dones++; done_t = t;
        chk(!busy && th_arm, "R5 busy low and th_arm high with done", int'(busy), 0);
        break;
      end
    end

    chk(rises_a == np, "R1 pulse count", rises_a, np);
    chk(done_t == (np + 1) * n, "R5 done time", done_t, (np + 1) * n);
    chk(high_a == np * h, "R2 clk_a high cycles", high_a, np * h);
    chk(rises_b == np && lag_err == 0, "R3 clk_b pulses and lag", lag_err, 0);
    chk(first_rise == n, "R4 first pulse one period after release", first_rise, n);
    chk(th_low == (np + 1) * n, "R4 track-and-hold release length", th_low, (np + 1) * n);

    exp_xfer = (v.mode == 2'b00 && !v.full) ? unmasked : 0;
    chk(pushes == exp_xfer, "R6 R9 R10 push count", pushes, exp_xfer);
    chk(chan_err == 0 && data_err == 0, "R6 channel order and data", chan_err + data_err, 0);
    exp_xfer = (v.mode == 2'b01 && !v.empty) ? unmasked : 0;
    chk(pops == exp_xfer, "R7 R9 R10 pop count", pops, exp_xfer);
    if (v.mode[1]) chk(pushes + pops == 0, "R8 bypass moves no data", pushes + pops, 0);
    if (pops > 0)
      chk(chip_dout == wr_base + DW'(pops - 1), "R7 chip_dout holds last popped word",
          int'(chip_dout), int'(wr_base) + pops - 1);

    @(negedge clk);
    chk(!done && !busy, "R5 done lasts one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    cfg_mode = 2'b00; cfg_cnt_sel = 2'd0; cfg_div_sel = 2'd0;
    cfg_chan_mask = '0; chip_din = '0; rd_full = 1'b0; wr_empty = 1'b0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(!busy && !done && th_arm && !clk_a && !clk_b && !rd_push && !wr_pop,
        "R12 reset state", int'({busy, done, th_arm, clk_a, clk_b, rd_push, wr_pop}), 7'b0010000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && th_arm, "R12 idle after reset release", int'(busy), 0);

    for (int k = 0; k < NV; k++) run_seq(VECS[k], 1'b0);

    // R11: second strobe and config change mid-readout are ignored
    run_seq('{2'b00, 2'd0, 2'd0, 64'h0, 1'b0, 1'b0}, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule